// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block is the slave-side command logic of a serial flash device that owns the protection and configuration bits of a two-byte status register. It watches the serial clock, the active-low chip select, the serial data input and the active-low write-protect pin. It decodes command frames in either SPI mode 0 or mode 3, and it applies the rules that decide whether a status write takes effect. Those rules are a write-enable latch that must be set in an earlier frame, an exact bit count checked when chip select is released, a one-way lock bit that works together with the write-protect pin, and a one-time-programmable (OTP) sector mode in which a status write sets a sticky OTP lock instead of changing the register.

All pin inputs are brought into the `clk_i` domain through a synchronizer of configurable depth. Serial data is sampled on each rising serial-clock edge while chip select is low. A frame is evaluated once, at the rising edge of chip select, and the bit counter and the captured opcode clear while chip select stays high. The outputs are the status bits, the write-enable latch, the OTP-mode and OTP-lock flags, and a flag that says whether the OTP sector may currently be written.

Top module: `flash_sr_ctrl`

## Requirements
- R1: After reset every output is 0.
- R2: A frame of exactly 8 bits carrying opcode 06h or 50h sets `wel_o`, and a frame of exactly 8 bits carrying 04h clears it.
- R3: A status write (opcode 01h, `wel_o` set, no lock active) that ends after exactly 16 bits loads `bpl_o` from data bit 7 and `bp_o` from data bits 4:2 of the first data byte, clears `qe_o`, and clears `wel_o`. Data is sent MSB first.
- R4: A status write that ends after exactly 24 bits loads the first data byte as in R3, loads `qe_o` from bit 1 of the second data byte, and clears `wel_o`.
- R5: A status write that ends at any bit count other than 16 or 24 changes nothing, including `wel_o`.
- R6: A status write issued while `wel_o` is 0 changes nothing.
- R7: While `wp_ni` is low and `bpl_o` is 1, a status write changes nothing, and `wel_o` stays set.
- R8: While `wp_ni` is low and `bpl_o` is 0, one status write may set `bpl_o` to 1 and change `bp_o` at the same time.
- R9: While `wp_ni` is high, a status write may return `bpl_o` from 1 to 0.
- R10: An 8-bit frame with opcode B1h sets `otp_mode_o`. An 8-bit frame with opcode 04h clears `otp_mode_o` and `wel_o`.
- R11: In OTP mode, an otherwise valid status write leaves `bp_o`, `bpl_o` and `qe_o` unchanged, sets `otp_lock_o` and clears `wel_o`. Once set, `otp_lock_o` stays 1 until reset.
- R12: `otp_wr_ok_o` is 1 exactly when `otp_mode_o` is 1, `bp_o` is 0 and `otp_lock_o` is 0.
- R13: An opcode-only command (06h, 50h, 04h, B1h) takes no effect unless its frame is exactly 8 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock; all pins are sampled in this domain |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data from the host, MSB first |
| wp_ni | input | 1 | Write-protect pin, active low |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 3 | Block-protect bits (bit 0 is the lowest data bit 2) |
| bpl_o | output | 1 | Block-protect lock bit |
| qe_o | output | 1 | Quad-enable configuration bit |
| otp_mode_o | output | 1 | OTP sector mode active |
| otp_lock_o | output | 1 | Sticky OTP sector lock |
| otp_wr_ok_o | output | 1 | OTP sector may be written |

## Verification
The bench builds the controller with `SYNC_STAGES` set to 3 rather than the default 2. The serial half period is four controller clocks, so the deeper synchronizer tests whether data still lines up with its clock edge when the pin-to-edge path is longer. With this setting the bench can send frames in mode 0 and in mode 3, frames that end one bit early or late, and oversized frames that push the bit counter into saturation. It can also toggle the write-protect pin between frames, which covers every branch of the lock and OTP rules.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_EWSR = 8'h50;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_OTPE = 8'hB1;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned DATA_BYTES = 2;
  localparam int unsigned DATA_W     = BYTE_W * DATA_BYTES;
  localparam int unsigned FRAME_MAX  = BYTE_W * (1 + DATA_BYTES);
  localparam int unsigned CNT_W      = $clog2(FRAME_MAX + 2);

  // field positions in the two data bytes
  localparam int unsigned LOCK_BIT = 7;
  localparam int unsigned BP_LSB   = 2;
  localparam int unsigned BP_W     = 3;
  localparam int unsigned QE_BIT   = 1;

  typedef struct packed {
    logic            bpl;
    logic [BP_W-1:0] bp;
    logic            qe;
  } stat_t;

  typedef struct packed {
    logic             done;
    logic [CNT_W-1:0] nbits;
    logic [7:0]       opcode;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/flash_sr_sync.sv
module flash_sr_sync #(
  parameter int unsigned     WIDTH  = 1,
  parameter int unsigned     STAGES = 2,
  parameter logic [WIDTH-1:0] RST   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= RST;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/flash_sr_frame.sv
module flash_sr_frame
  import flash_sr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sck_s_i,
  input  logic   csn_s_i,
  input  logic   sdi_s_i,
  output frame_t frame_o
);
  logic              sck_d_q, csn_d_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        op_q;
  logic [DATA_W-1:0] sh_q;
  logic              sck_rise, cs_rise, cnt_sat;

  assign sck_rise = sck_s_i & ~sck_d_q & ~csn_s_i;
  assign cs_rise  = csn_s_i & ~csn_d_q;
  assign cnt_sat  = (cnt_q == CNT_W'(FRAME_MAX + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      csn_d_q <= 1'b1;
    end else begin
      sck_d_q <= sck_s_i;
      csn_d_q <= csn_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= '0;
      sh_q  <= '0;
    end else if (csn_s_i) begin
      // cleared only once the release edge has been consumed
      if (!cs_rise) begin
        cnt_q <= '0;
        op_q  <= '0;
      end
    end else if (sck_rise) begin
      if (!cnt_sat) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(BYTE_W - 1)) op_q <= {sh_q[6:0], sdi_s_i};
      sh_q <= {sh_q[DATA_W-2:0], sdi_s_i};
    end
  end

  assign frame_o.done   = cs_rise;
  assign frame_o.nbits  = cnt_q;
  assign frame_o.opcode = op_q;
  assign frame_o.data   = sh_q;
endmodule

// File: rtl/flash_sr_regs.sv
module flash_sr_regs
  import flash_sr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  frame_t frame_i,
  input  logic   wp_s_i,
  output stat_t  stat_o,
  output logic   wel_o,
  output logic   otp_mode_o,
  output logic   otp_lock_o
);
  stat_t stat_q;
  logic  wel_q, otp_mode_q, otp_lock_q;
  logic  len_op, len_one, len_two, is_wrsr, wr_valid, wr_open;
  logic [BYTE_W-1:0] byte1, byte2;
  stat_t stat_new;

  assign len_op  = frame_i.nbits == CNT_W'(BYTE_W);
  assign len_one = frame_i.nbits == CNT_W'(2 * BYTE_W);
  assign len_two = frame_i.nbits == CNT_W'(3 * BYTE_W);
  assign is_wrsr = frame_i.opcode == OP_WRSR;

  // first byte sits low after a short frame, high after a full one
  assign byte1 = len_two ? frame_i.data[DATA_W-1 -: BYTE_W] : frame_i.data[BYTE_W-1:0];
  assign byte2 = frame_i.data[BYTE_W-1:0];

  always_comb begin
    stat_new.bpl = byte1[LOCK_BIT];
    stat_new.bp  = byte1[BP_LSB +: BP_W];
    stat_new.qe  = len_two ? byte2[QE_BIT] : 1'b0;
  end

  assign wr_valid = frame_i.done & is_wrsr & (len_one | len_two) & wel_q;
  assign wr_open  = wp_s_i | ~stat_q.bpl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      wel_q      <= 1'b0;
      otp_mode_q <= 1'b0;
      otp_lock_q <= 1'b0;
    end else if (frame_i.done && len_op) begin
      unique case (frame_i.opcode)
        OP_WREN, OP_EWSR: wel_q <= 1'b1;
        OP_WRDI: begin
          wel_q      <= 1'b0;
          otp_mode_q <= 1'b0;
        end
        OP_OTPE: otp_mode_q <= 1'b1;
        default: ;
      endcase
    end else if (wr_valid) begin
      if (otp_mode_q) begin
        otp_lock_q <= 1'b1;
        wel_q      <= 1'b0;
      end else if (wr_open) begin
        stat_q <= stat_new;
        wel_q  <= 1'b0;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{byte1[6:5], byte1[1:0], byte2[7:2], byte2[0]};

  assign stat_o     = stat_q;
  assign wel_o      = wel_q;
  assign otp_mode_o = otp_mode_q;
  assign otp_lock_o = otp_lock_q;
endmodule

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
  import flash_sr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sck_i,
  input  logic            csn_i,
  input  logic            sdi_i,
  input  logic            wp_ni,
  output logic            wel_o,
  output logic [BP_W-1:0] bp_o,
  output logic            bpl_o,
  output logic            qe_o,
  output logic            otp_mode_o,
  output logic            otp_lock_o,
  output logic            otp_wr_ok_o
);
  logic [3:0] pins, pins_s;
  logic       sck_s, csn_s, sdi_s, wp_s;
  frame_t     frame;
  logic       frame_done;
  stat_t      stat;

  assign pins = {wp_ni, csn_i, sck_i, sdi_i};

  flash_sr_sync #(
    .WIDTH (4),
    .STAGES(SYNC_STAGES),
    .RST   (4'b0100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins),
    .q_o   (pins_s)
  );

  assign {wp_s, csn_s, sck_s, sdi_s} = pins_s;

  flash_sr_frame i_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(sck_s),
    .csn_s_i(csn_s),
    .sdi_s_i(sdi_s),
    .frame_o(frame)
  );

  assign frame_done = frame.done;

  flash_sr_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame),
    .wp_s_i    (wp_s),
    .stat_o    (stat),
    .wel_o     (wel_o),
    .otp_mode_o(otp_mode_o),
    .otp_lock_o(otp_lock_o)
  );

  assign bp_o        = stat.bp;
  assign bpl_o       = stat.bpl;
  assign qe_o        = stat.qe;
  assign otp_wr_ok_o = otp_mode_o & ~|stat.bp & ~otp_lock_o;
endmodule

// File: rtl/flash_sr_ctrl_chk.sv
module flash_sr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_s,
  input logic       frame_done,
  input logic       wel_o,
  input logic [2:0] bp_o,
  input logic       bpl_o,
  input logic       qe_o,
  input logic       otp_mode_o,
  input logic       otp_lock_o
);
  // R6
  wel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wel_o |=> ($stable(bp_o) && $stable(bpl_o) && $stable(qe_o)));

  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpl_o && !wp_s) |=> (bpl_o && $stable(bp_o) && $stable(qe_o)));

  // R2
  wel_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> $past(frame_done));

  // R4
  qe_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qe_o) |-> ($past(frame_done) && !$past(otp_mode_o)));

  // R11
  otp_lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otp_lock_o |=> otp_lock_o);

  // R11
  otp_lock_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(otp_lock_o) |-> $past(otp_mode_o));
endmodule

bind flash_sr_ctrl flash_sr_ctrl_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wp_s      (wp_s),
  .frame_done(frame_done),
  .wel_o     (wel_o),
  .bp_o      (bp_o),
  .bpl_o     (bpl_o),
  .qe_o      (qe_o),
  .otp_mode_o(otp_mode_o),
  .otp_lock_o(otp_lock_o)
);

// File: tb/test_flash_sr_ctrl.sv
`timescale 1ns/1ps
module test_flash_sr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0, wp_n = 1'b1;
  logic wel, bpl, qe, otp_mode, otp_lock, otp_ok;
  logic [2:0] bp;

  always #2.5 clk = ~clk;

  flash_sr_ctrl #(.SYNC_STAGES(3)) i_flash_sr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
    .wp_ni(wp_n), .wel_o(wel), .bp_o(bp), .bpl_o(bpl), .qe_o(qe),
    .otp_mode_o(otp_mode), .otp_lock_o(otp_lock), .otp_wr_ok_o(otp_ok)
  );

  typedef struct {
    string      tag;
    logic [8:0] exp;
  } item_t;

  item_t q[$];
  int    n_run = 0, n_fail = 0;
  event  frame_ev;

  // reference state built from the requirements
  logic       m_wel = 0, m_bpl = 0, m_qe = 0, m_otp = 0, m_lock = 0;
  logic [2:0] m_bp = 0;

  function automatic logic [8:0] snap_exp();
    logic ok;
    ok = m_otp && (m_bp == 3'd0) && !m_lock;
    return {m_wel, m_bpl, m_bp, m_qe, m_otp, m_lock, ok};
  endfunction

  function automatic logic [8:0] snap_dut();
    return {wel, bpl, bp, qe, otp_mode, otp_lock, otp_ok};
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b {wel,bpl,bp,qe,otp,lock,ok}", tag, act, exp);
    end
  endtask

  task automatic model(logic [31:0] b, int n, logic wp);
    logic [7:0] op, s1;
    if (n < 8) return;
    op = b[n-1 -: 8];
    if (n == 8) begin
      case (op)
        8'h06, 8'h50: m_wel = 1;
        8'h04: begin m_wel = 0; m_otp = 0; end
        8'hB1: m_otp = 1;
        default: ;
      endcase
    end else if (op == 8'h01 && (n == 16 || n == 24) && m_wel) begin
      if (m_otp) begin
        m_lock = 1; m_wel = 0;
      end else if (wp || !m_bpl) begin
        s1    = (n == 16) ? b[7:0] : b[15:8];
        m_bpl = s1[7];
        m_bp  = s1[4:2];
        m_qe  = (n == 24) ? b[1] : 1'b0;
        m_wel = 0;
      end
    end
  endtask

  task automatic frame(string tag, logic [31:0] b, int n, bit mode3);
    sck = mode3;
    repeat (4) @(negedge clk);
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0;
      sdi = b[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    if (!mode3) sck = 1'b0;
    repeat (4) @(negedge clk);
    csn = 1'b1;
    model(b, n, wp_n);
    q.push_back('{tag: tag, exp: snap_exp()});
    -> frame_ev;
    repeat (20) @(negedge clk);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(frame_ev);
      repeat (14) @(negedge clk);
      it = q.pop_front();
      check(it.tag, snap_dut(), it.exp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset", snap_dut(), 9'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    frame("R6 write without latch", 32'h019C, 16, 0);
    frame("R2 wren sets latch", 32'h06, 8, 0);
    frame("R2 wrdi clears latch", 32'h04, 8, 0);
    frame("R13 nine-bit enable ignored", 32'h0D, 9, 0);
    frame("R2 ewsr mode3 sets latch", 32'h50, 8, 1);
    frame("R4 two-byte write", 32'h010C02, 24, 0);
    frame("R2 wren", 32'h06, 8, 1);
    frame("R5 twelve-bit write ignored", 32'h01F, 12, 0);
    frame("R5 32-bit write ignored", 32'h01FCFF00, 32, 0);
    frame("R3 one-byte write clears qe", 32'h0114, 16, 0);
    wp_n = 1'b0;
    frame("R2 wren", 32'h06, 8, 0);
    frame("R8 lock set with bp", 32'h0188, 16, 0);
    frame("R12 otp entry blocked by bp", 32'hB1, 8, 0);
    frame("R10 wrdi leaves otp", 32'h04, 8, 0);
    frame("R2 wren", 32'h06, 8, 0);
    frame("R7 locked write ignored", 32'h0100, 16, 0);
    wp_n = 1'b1;
    repeat (10) @(negedge clk);
    frame("R9 unlock with wp high", 32'h0100, 16, 0);
    frame("R10 enter otp", 32'hB1, 8, 1);
    frame("R2 wren", 32'h06, 8, 0);
    frame("R11 otp write locks sector", 32'h011C03, 24, 0);
    frame("R10 exit otp", 32'h04, 8, 0);
    frame("R11 lock sticky after reentry", 32'hB1, 8, 0);
    frame("R13 oversize exit ignored", 32'h0400, 16, 0);

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule